// File: doc/BRIEF.md
# Fracture-Aware Nested Translation Cache

This block is a small fully associative translation cache for a core that runs guests under hardware virtualization. Each entry maps a guest-virtual page directly to a host-physical page; the intermediate guest-physical address is never stored. A fill supplies the virtual and physical page numbers together with two page-size flags: one for the guest mapping and one for the nested (host) mapping. From these flags the block picks the stored granularity, which is the smaller of the two sizes. It marks an entry as *fractured* when a 2MB guest page is backed by 4KB host pages. In that case each 4KB piece of the guest page occupies its own entry.

Lookups are combinational: a virtual address goes in, and a hit flag and physical address come out in the same cycle. Two invalidation commands are accepted. A full flush empties the cache. A single-page invalidate removes the entries covering one address. A fracture tracker state machine has two states, `ST_CLEAN` (no fractured entry can be resident) and `ST_FRAC` (one may be). Transition `CLEAN->FRAC` is taken on any fractured fill. Transition `FRAC->CLEAN` is taken on a full flush or on an escalated invalidate. In `ST_FRAC`, a single-page invalidate is escalated to a full flush, because the scattered 4KB pieces of the guest page cannot be found by one address compare. Each escalation produces a one-cycle pulse.

Top module: `frac_tlb`

## Requirements
- R1: After reset, no lookup hits and `esc_pulse` is low.
- R2: A lookup hit returns, in the same cycle, the stored physical page concatenated with the low address bits: 12 offset bits for a 4KB entry, 21 offset bits for a 2MB entry. On a miss, `lk_hit` is 0.
- R3: The stored granularity is 2MB only when both `fill_gbig` and `fill_hbig` are 1. A fill with `fill_gbig`=1 and `fill_hbig`=0 stores a fractured 4KB entry, so other 4KB pieces of the same 2MB guest page miss.
- R4: `flush_en` invalidates every entry. A lookup in the same cycle already misses.
- R5: In `ST_CLEAN`, `inv_en` removes only the entries whose stored page covers `inv_vpn`. The other entries keep hitting, and `esc_pulse` stays low.
- R6: In `ST_FRAC`, `inv_en` clears every entry, even when `inv_vpn` matches nothing.
- R7: A fill with `fill_gbig`=0 and `fill_hbig`=1 stores an ordinary 4KB entry and never causes escalation.
- R8: The fracture state returns to `ST_CLEAN` after a full flush or an escalated invalidate. A later invalidate is then not escalated unless a new fractured fill has arrived.
- R9: A fill that matches no live entry writes the slot at a round-robin pointer. The pointer advances by one modulo 16. After 16 such fills, the next one evicts the oldest entry.
- R10: A fill whose address hits a live entry overwrites that entry and does not advance the pointer.
- R11: An invalidate issued in the same cycle as a lookup takes effect before that lookup.
- R12: `esc_pulse` is high for exactly the one cycle after an escalated invalidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | PA_W | Lookup physical address (0 on miss) |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VA_W-12 | Fill virtual page number (4KB units) |
| fill_ppn | input | PA_W-12 | Fill physical page number (4KB units) |
| fill_gbig | input | 1 | Guest mapping is 2MB |
| fill_hbig | input | 1 | Host mapping is 2MB |
| inv_en | input | 1 | Single-page invalidate |
| inv_vpn | input | VA_W-12 | Page number to invalidate |
| flush_en | input | 1 | Invalidate all entries |
| esc_pulse | output | 1 | One-cycle pulse after an escalated invalidate |

## Verification
The hardest situation to reach is an escalation whose target address matches no entry at all. To reach it, the bench first loads a guest-2MB/host-4KB fill alongside unrelated entries, then invalidates an address far from every cached page. It confirms that all entries vanish and that the pulse appears exactly once. The bench then returns the tracker to `ST_CLEAN` by each of the two exits (flush and escalation) and repeats a targeted invalidate, which must remain narrow. Replacement order is reached by filling all sixteen slots from a known set of pages, refilling one of them in place, and then checking which pages are evicted by the next fills.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic {
        ST_CLEAN = 1'b0,
        ST_FRAC  = 1'b1
    } frac_state_e;

    typedef struct packed {
        logic big;   // stored granularity is the large page
        logic frac;  // large guest page split over small host pages
    } fill_kind_t;

    function automatic fill_kind_t classify(input logic gbig, input logic hbig);
        fill_kind_t k;
        k.big  = gbig & hbig;
        k.frac = gbig & ~hbig;
        return k;
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int VPN_W = 20,
    parameter int SUB_W = 9
) (
    input  logic             ent_valid,
    input  logic             ent_big,
    input  logic [VPN_W-1:0] ent_vpn,
    input  logic [VPN_W-1:0] probe_vpn,
    output logic             hit
);
    always_comb begin
        if (ent_big)
            hit = ent_valid && (ent_vpn[VPN_W-1:SUB_W] == probe_vpn[VPN_W-1:SUB_W]);
        else
            hit = ent_valid && (ent_vpn == probe_vpn);
    end
endmodule

// File: rtl/tlb_rr.sv
module tlb_rr #(
    parameter int ENTRIES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv,
    output logic [$clog2(ENTRIES)-1:0] ptr
);
    localparam int IDX_W = $clog2(ENTRIES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/tlb_frac_fsm.sv
module tlb_frac_fsm
    import tlb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        inv_en,
    input  logic        flush_en,
    input  logic        fill_frac,
    output logic        escalate,
    output logic        esc_pulse,
    output frac_state_e state
);
    frac_state_e state_d;
    logic        esc_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CLEAN;
            esc_q <= 1'b0;
        end else begin
            state <= state_d;
            esc_q <= escalate;
        end
    end

    // next state: a fill lands after any clearing in the same cycle
    always_comb begin
        state_d = state;
        unique case (state)
            ST_CLEAN: if (fill_frac) state_d = ST_FRAC;
            ST_FRAC:  if ((flush_en || inv_en) && !fill_frac) state_d = ST_CLEAN;
            default:  state_d = ST_CLEAN;
        endcase
    end

    // outputs
    always_comb begin
        escalate  = 1'b0;
        esc_pulse = esc_q;
        unique case (state)
            ST_CLEAN: escalate = 1'b0;
            ST_FRAC:  escalate = inv_en;
            default:  escalate = 1'b0;
        endcase
    end
endmodule

// File: rtl/frac_tlb.sv
module frac_tlb
    import tlb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int ENTRIES   = 16,
    parameter int SMALL_OFF = 12,
    parameter int BIG_OFF   = 21
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [VA_W-1:0]           lk_va,
    output logic                      lk_hit,
    output logic [PA_W-1:0]           lk_pa,
    input  logic                      fill_en,
    input  logic [VA_W-SMALL_OFF-1:0] fill_vpn,
    input  logic [PA_W-SMALL_OFF-1:0] fill_ppn,
    input  logic                      fill_gbig,
    input  logic                      fill_hbig,
    input  logic                      inv_en,
    input  logic [VA_W-SMALL_OFF-1:0] inv_vpn,
    input  logic                      flush_en,
    output logic                      esc_pulse
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int VPN_W = VA_W - SMALL_OFF;
    localparam int PPN_W = PA_W - SMALL_OFF;
    localparam int SUB_W = BIG_OFF - SMALL_OFF;

    logic [ENTRIES-1:0] valid_q, big_q, frac_q;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];

    logic [ENTRIES-1:0] inv_hitv, kill_vec, live, lk_hitv, fill_hitv, valid_d;
    logic [VPN_W-1:0]   lk_vpn;
    logic [IDX_W-1:0]   rr_ptr, tgt;
    logic               fill_any, kill_all, escalate;
    fill_kind_t         fk;
    frac_state_e        frac_state;

    assign lk_vpn = lk_va[VA_W-1:SMALL_OFF];
    assign fk     = classify(fill_gbig, fill_hbig);

    tlb_frac_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv_en    (inv_en),
        .flush_en  (flush_en),
        .fill_frac (fill_en && fk.frac),
        .escalate  (escalate),
        .esc_pulse (esc_pulse),
        .state     (frac_state)
    );

    tlb_rr #(.ENTRIES(ENTRIES)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (fill_en && !fill_any),
        .ptr   (rr_ptr)
    );

    assign kill_all = flush_en || escalate;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        tlb_match #(.VPN_W(VPN_W), .SUB_W(SUB_W)) u_inv (
            .ent_valid (valid_q[i]),
            .ent_big   (big_q[i]),
            .ent_vpn   (tag_q[i]),
            .probe_vpn (inv_vpn),
            .hit       (inv_hitv[i])
        );

        assign kill_vec[i] = kill_all || (inv_en && inv_hitv[i]);
        assign live[i]     = valid_q[i] && !kill_vec[i];

        tlb_match #(.VPN_W(VPN_W), .SUB_W(SUB_W)) u_lk (
            .ent_valid (live[i]),
            .ent_big   (big_q[i]),
            .ent_vpn   (tag_q[i]),
            .probe_vpn (lk_vpn),
            .hit       (lk_hitv[i])
        );

        tlb_match #(.VPN_W(VPN_W), .SUB_W(SUB_W)) u_fill (
            .ent_valid (live[i]),
            .ent_big   (big_q[i]),
            .ent_vpn   (tag_q[i]),
            .probe_vpn (fill_vpn),
            .hit       (fill_hitv[i])
        );

        assign valid_d[i] = live[i] || (fill_en && (tgt == IDX_W'(i)));

        always_ff @(posedge clk) begin
            if (fill_en && (tgt == IDX_W'(i))) begin
                tag_q[i] <= fill_vpn;
                ppn_q[i] <= fill_ppn;
                big_q[i] <= fk.big;
                frac_q[i] <= fk.frac;
            end
        end
    end

    // fill target: lowest live match, else the replacement pointer
    always_comb begin
        fill_any = 1'b0;
        tgt      = rr_ptr;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_hitv[i] && !fill_any) begin
                fill_any = 1'b1;
                tgt      = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            valid_q <= '0;
        else
            valid_q <= valid_d;
    end

    // lookup result: lowest matching entry
    always_comb begin
        lk_hit = 1'b0;
        lk_pa  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hitv[i] && !lk_hit) begin
                lk_hit = 1'b1;
                if (big_q[i])
                    lk_pa = {ppn_q[i][PPN_W-1:SUB_W], lk_va[BIG_OFF-1:0]};
                else
                    lk_pa = {ppn_q[i], lk_va[SMALL_OFF-1:0]};
            end
        end
    end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               inv_en,
    input logic               flush_en,
    input logic               fill_en,
    input logic               fill_gbig,
    input logic               fill_hbig,
    input logic               lk_hit,
    input logic               esc_pulse,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] frac_q,
    input frac_state_e        frac_state
);
    p_flush_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_en && !fill_en) |=> (valid_q == '0));

    p_flush_lookup_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |-> !lk_hit);

    p_esc_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && frac_state == ST_FRAC && !fill_en) |=> (valid_q == '0));

    p_pulse_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        esc_pulse |-> ($past(inv_en) && $past(frac_state) == ST_FRAC));

    p_frac_tracked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(valid_q & frac_q)) |-> (frac_state == ST_FRAC));

    p_frac_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fill_gbig && !fill_hbig) |=> (frac_state == ST_FRAC));

    p_clean_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && frac_state == ST_CLEAN) |=> !esc_pulse);
endmodule

bind frac_tlb tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inv_en     (inv_en),
    .flush_en   (flush_en),
    .fill_en    (fill_en),
    .fill_gbig  (fill_gbig),
    .fill_hbig  (fill_hbig),
    .lk_hit     (lk_hit),
    .esc_pulse  (esc_pulse),
    .valid_q    (valid_q),
    .frac_q     (frac_q),
    .frac_state (frac_state)
);

// File: tb/test_frac_tlb.sv
module test_frac_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic        fill_gbig = 1'b0;
    logic        fill_hbig = 1'b0;
    logic        inv_en = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        flush_en = 1'b0;
    logic        esc_pulse;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    frac_tlb i_frac_tlb (
        .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_gbig(fill_gbig), .fill_hbig(fill_hbig), .inv_en(inv_en),
        .inv_vpn(inv_vpn), .flush_en(flush_en), .esc_pulse(esc_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] va, input logic eh, input logic [31:0] ep, input string req);
        lk_va = va;
        #1;
        chk(req, {31'b0, lk_hit}, {31'b0, eh});
        if (eh) chk(req, lk_pa, ep);
        @(negedge clk);
    endtask

    task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic g, input logic h);
        fill_en = 1'b1; fill_vpn = va[31:12]; fill_ppn = pa[31:12];
        fill_gbig = g; fill_hbig = h;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic inval(input logic [31:0] va, input logic exp_esc, input string req);
        inv_en = 1'b1; inv_vpn = va[31:12];
        @(negedge clk);
        inv_en = 1'b0;
        chk({req, " pulse"}, {31'b0, esc_pulse}, {31'b0, exp_esc});
        @(negedge clk);
        chk("R12 pulse width", {31'b0, esc_pulse}, 32'd0);
    endtask

    task automatic flush();
        flush_en = 1'b1;
        @(negedge clk);
        flush_en = 1'b0;
    endtask

    task automatic t_reset();
        lk_va = 32'h0000_0000;
        #1;
        chk("R1 hit after reset", {31'b0, lk_hit}, 32'd0);
        chk("R1 pulse after reset", {31'b0, esc_pulse}, 32'd0);
    endtask

    task automatic t_sizes();
        flush();
        fill(32'h0040_0000, 32'h1220_0000, 1'b1, 1'b1);
        look(32'h0045_6789, 1'b1, 32'h1225_6789, "R2 R3 large entry");
        fill(32'h0100_0000, 32'h0ABC_D000, 1'b0, 1'b0);
        look(32'h0100_0FFF, 1'b1, 32'h0ABC_DFFF, "R2 small entry");
        look(32'h0100_1000, 1'b0, 32'h0, "R2 small neighbour miss");
        inval(32'h0100_0000, 1'b0, "R5 narrow");
        look(32'h0100_0000, 1'b0, 32'h0, "R5 target removed");
        look(32'h0045_6789, 1'b1, 32'h1225_6789, "R5 other kept");
        inval(32'h004F_F000, 1'b0, "R5 inside large");
        look(32'h0040_0000, 1'b0, 32'h0, "R5 large removed");
    endtask

    task automatic t_fracture();
        flush();
        fill(32'h0060_0000, 32'h2000_0000, 1'b1, 1'b0);
        look(32'h0060_0ABC, 1'b1, 32'h2000_0ABC, "R3 fractured piece");
        look(32'h0060_1000, 1'b0, 32'h0, "R3 other piece misses");
        fill(32'h0300_0000, 32'h3000_0000, 1'b0, 1'b0);
        inval(32'h7000_0000, 1'b1, "R6 R12 escalate");
        look(32'h0300_0010, 1'b0, 32'h0, "R6 unrelated cleared");
        look(32'h0060_0ABC, 1'b0, 32'h0, "R6 fractured cleared");
        fill(32'h0300_0000, 32'h3000_0000, 1'b0, 1'b0);
        fill(32'h0301_0000, 32'h3100_0000, 1'b0, 1'b0);
        inval(32'h0300_0000, 1'b0, "R8 cleared by escalation");
        look(32'h0301_0004, 1'b1, 32'h3100_0004, "R8 neighbour kept");
        look(32'h0300_0000, 1'b0, 32'h0, "R8 target removed");
        fill(32'h0060_0000, 32'h2000_0000, 1'b1, 1'b0);
        flush();
        fill(32'h0301_0000, 32'h3100_0000, 1'b0, 1'b0);
        inval(32'h7000_0000, 1'b0, "R8 cleared by flush");
        look(32'h0301_0004, 1'b1, 32'h3100_0004, "R8 entry kept after flush");
    endtask

    task automatic t_small_guest();
        flush();
        fill(32'h0500_0000, 32'h4000_0000, 1'b0, 1'b1);
        look(32'h0500_0123, 1'b1, 32'h4000_0123, "R7 small entry");
        look(32'h0500_1000, 1'b0, 32'h0, "R7 stored at 4KB");
        inval(32'h7000_0000, 1'b0, "R7 no escalation");
        look(32'h0500_0123, 1'b1, 32'h4000_0123, "R7 entry kept");
    endtask

    task automatic t_same_cycle();
        flush();
        fill(32'h0900_0000, 32'h6000_0000, 1'b0, 1'b0);
        flush_en = 1'b1; lk_va = 32'h0900_0000;
        #1;
        chk("R4 lookup during flush", {31'b0, lk_hit}, 32'd0);
        @(negedge clk);
        flush_en = 1'b0;
        look(32'h0900_0000, 1'b0, 32'h0, "R4 after flush");
        fill(32'h0900_0000, 32'h6000_0000, 1'b0, 1'b0);
        fill(32'h0901_0000, 32'h6100_0000, 1'b0, 1'b0);
        inv_en = 1'b1; inv_vpn = 20'h09000; lk_va = 32'h0900_0000;
        #1;
        chk("R11 lookup during invalidate", {31'b0, lk_hit}, 32'd0);
        lk_va = 32'h0901_0000;
        #0.5;
        chk("R11 other lookup hits", {31'b0, lk_hit}, 32'd1);
        @(negedge clk);
        inv_en = 1'b0;
    endtask

    task automatic t_replace();
        flush();
        for (int i = 0; i < 16; i++)
            fill(32'h0800_0000 + 32'(i) * 32'h1000, 32'h5000_0000 + 32'(i) * 32'h1000, 1'b0, 1'b0);
        fill(32'h0800_5000, 32'h5F00_0000, 1'b0, 1'b0);
        look(32'h0800_5000, 1'b1, 32'h5F00_0000, "R10 overwrite in place");
        fill(32'h0801_0000, 32'h5001_0000, 1'b0, 1'b0);
        look(32'h0800_0000, 1'b0, 32'h0, "R9 oldest evicted");
        look(32'h0800_1000, 1'b1, 32'h5000_1000, "R9 second kept");
        look(32'h0801_0000, 1'b1, 32'h5001_0000, "R9 new entry");
        look(32'h0800_5000, 1'b1, 32'h5F00_0000, "R10 refilled kept");
        fill(32'h0801_1000, 32'h5001_1000, 1'b0, 1'b0);
        look(32'h0800_1000, 1'b0, 32'h0, "R10 pointer not advanced");
        look(32'h0800_F000, 1'b1, 32'h5000_F000, "R9 last kept");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_sizes();
        t_fracture();
        t_small_guest();
        t_same_cycle();
        t_replace();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule